// File: doc/BRIEF.md
# Framebuffer Burst Fetch Engine

This block streams a frame of pixel words from memory into a local first-in first-out store. A display timing engine drains the store. Software sets three things: a base byte address, the frame size counted in 32-bit words, and a burst length. The burst length is written as its value minus one. While enabled, the block issues fixed-length read bursts on a simple request/response memory port, and it does so only when the store has room for them. When the last word of a frame has been fetched, the fetch pointer returns to the base address and the next frame starts there.

A fetch-reset control returns the word pointer to the start of the frame and empties the store. The enable control lets new bursts start. Configuration is changed only while fetching is disabled, no burst is outstanding and fetch-reset has been applied. On the pixel side, the consumer reads words in the order they were fetched. If it reads while the store is empty, it gets an underflow flag.

Top module: `fbf_fetch_engine`

## Requirements
- R1: While `ctl_reset` is high the block is idle, and the first burst after it is released starts at `cfg_base`.
- R2: Each request carries a byte address equal to `cfg_base` + 4 × (word offset within the frame). Consecutive bursts of one frame follow each other with no gaps.
- R3: A request's length field holds beats − 1. The beat count is `cfg_burst_m1` + 1, except that it shrinks to the words left in the frame (`cfg_frame_words`) when fewer remain.
- R4: `frame_done` is high for exactly one cycle, in the cycle after the last response word of a frame is accepted. The following burst then starts at `cfg_base` again.
- R5: A new burst is requested only when the store fill level is below FIFO_DEPTH − (2 × burst length + 3). The store never overflows.
- R6: Clearing `ctl_enable` prevents any new request, but a burst already issued still delivers all of its words into the store.
- R7: `busy` is high from the cycle a request is presented until the cycle after its last response word. It is low otherwise.
- R8: `pix_data` shows the oldest stored word while `pix_empty` is low, and `pix_rd` removes it. Words come out in fetch order.
- R9: When `pix_rd` is asserted while the store is empty, `pix_underflow` is high for one cycle on the next cycle, and nothing is removed.
- R10: `ctl_reset` discards every word in the store, so that `pix_empty` is high the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Frame base byte address |
| cfg_frame_words | input | FRAME_W | 32-bit words per frame |
| cfg_burst_m1 | input | BURST_W | Burst length minus one |
| ctl_enable | input | 1 | Allows new bursts to start |
| ctl_reset | input | 1 | Fetch reset: pointer to base, store flushed |
| mem_req_valid | output | 1 | Read request presented |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_len_m1 | output | BURST_W | Request beats minus one |
| mem_rsp_valid | input | 1 | Response word valid |
| mem_rsp_data | input | DATA_W | Response word |
| pix_rd | input | 1 | Consumer removes the head word |
| pix_data | output | DATA_W | Head word of the store |
| pix_empty | output | 1 | Store holds no word |
| pix_underflow | output | 1 | Read of an empty store, one-cycle pulse |
| busy | output | 1 | A burst is outstanding |
| frame_done | output | 1 | Last word of a frame received, one-cycle pulse |

## Verification
A word pointer that has gone wrong appears at the very next request as an address or length that does not match the frame position. If the wrap is wrong, the request after a frame end does not return to the base address and `frame_done` arrives on the wrong cycle. A corrupted store pointer or fill level causes the scoreboard to find a word out of order within one read. It can also move the cycle in which refills stop or resume when the threshold test drains words one at a time.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_DATA = 2'd2
   } fetch_state_e;
endpackage

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
   parameter int DEPTH = 512,
   parameter int DW    = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop_req,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic [LW-1:0] level,
   output logic          underflow
);
   logic [DW-1:0] mem [DEPTH];
   logic [LW-1:0] wr_ptr, rd_ptr;
   logic          pop;

   assign level = wr_ptr - rd_ptr;
   assign empty = (level == '0);
   assign pop   = pop_req && !empty;
   assign rdata = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         underflow <= 1'b0;
      end else if (flush) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         underflow <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         underflow <= pop_req && empty;
      end
   end

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (level < LW'(DEPTH)));
   a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   a_r9_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push && !flush) |=> empty);
endmodule

// File: rtl/fbf_burst_ctrl.sv
module fbf_burst_ctrl
   import fbf_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int FRAME_W = 24,
   parameter int BURST_W = 5,
   parameter int DEPTH   = 512,
   localparam int LW     = $clog2(DEPTH) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               enable,
   input  logic [ADDR_W-1:0]  base,
   input  logic [FRAME_W-1:0] frame_words,
   input  logic [BURST_W-1:0] burst_m1,
   input  logic [LW-1:0]      fifo_level,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [BURST_W-1:0] req_len_m1,
   input  logic               rsp_valid,
   output logic               push,
   output logic               busy,
   output logic               frame_done
);
   fetch_state_e       state;
   logic [FRAME_W-1:0] word_off, cur_len, remaining, len_full, off_next;
   logic [BURST_W:0]   burst_len;
   logic [BURST_W+2:0] guard;
   logic [LW-1:0]      thresh;
   logic [BURST_W-1:0] beats_left;
   logic               can_issue, frame_end;

   assign burst_len = {1'b0, burst_m1} + 1'b1;
   assign guard     = (BURST_W+3)'({burst_len, 1'b0}) + (BURST_W+3)'(3);
   assign thresh    = LW'(DEPTH) - LW'(guard);
   assign remaining = frame_words - word_off;
   assign len_full  = (remaining < FRAME_W'(burst_len)) ? remaining : FRAME_W'(burst_len);
   assign off_next  = word_off + cur_len;
   assign frame_end = (off_next >= frame_words);
   assign can_issue = enable && !soft_rst && (frame_words != '0) && (fifo_level < thresh);

   assign req_valid  = (state == FS_REQ);
   assign req_addr   = base + (ADDR_W'(word_off) << 2);
   assign req_len_m1 = BURST_W'(cur_len - FRAME_W'(1));
   assign push       = (state == FS_DATA) && rsp_valid;
   assign busy       = (state != FS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= FS_IDLE;
         word_off   <= '0;
         cur_len    <= '0;
         beats_left <= '0;
         frame_done <= 1'b0;
      end else if (soft_rst) begin
         state      <= FS_IDLE;
         word_off   <= '0;
         beats_left <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         case (state)
            FS_IDLE: if (can_issue) begin
               cur_len <= len_full;
               state   <= FS_REQ;
            end
            FS_REQ: if (req_ready) begin
               beats_left <= BURST_W'(cur_len - FRAME_W'(1));
               state      <= FS_DATA;
            end
            FS_DATA: if (rsp_valid) begin
               if (beats_left == '0) begin
                  state <= FS_IDLE;
                  if (frame_end) begin
                     word_off   <= '0;
                     frame_done <= 1'b1;
                  end else begin
                     word_off <= off_next;
                  end
               end else begin
                  beats_left <= beats_left - 1'b1;
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   a_r1_soft_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !busy);
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
   a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len_m1 <= burst_m1));
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
   a_r5_threshold_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> ($past(fifo_level) < $past(thresh)));
   a_r6_no_issue_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !busy) |=> !busy);
endmodule

// File: rtl/fbf_fetch_engine.sv
module fbf_fetch_engine #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int FRAME_W    = 24,
   parameter int BURST_W    = 5,
   parameter int FIFO_DEPTH = 512,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [FRAME_W-1:0] cfg_frame_words,
   input  logic [BURST_W-1:0] cfg_burst_m1,
   input  logic               ctl_enable,
   input  logic               ctl_reset,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [ADDR_W-1:0]  mem_req_addr,
   output logic [BURST_W-1:0] mem_req_len_m1,
   input  logic               mem_rsp_valid,
   input  logic [DATA_W-1:0]  mem_rsp_data,
   input  logic               pix_rd,
   output logic [DATA_W-1:0]  pix_data,
   output logic               pix_empty,
   output logic               pix_underflow,
   output logic               busy,
   output logic               frame_done
);
   logic [LVL_W-1:0] fill;
   logic             push;

   generate
      if (FIFO_DEPTH != 512 && FIFO_DEPTH != 2048) begin : g_bad_depth
         $error("fbf_fetch_engine: FIFO_DEPTH must be 512 or 2048");
      end
      if (2 * (2 ** BURST_W) + 3 >= FIFO_DEPTH) begin : g_bad_burst
         $error("fbf_fetch_engine: longest burst leaves no refill threshold");
      end
      if (FRAME_W <= BURST_W + 1) begin : g_bad_frame
         $error("fbf_fetch_engine: FRAME_W must exceed BURST_W + 1");
      end
   endgenerate

   fbf_burst_ctrl #(
      .ADDR_W (ADDR_W),
      .FRAME_W(FRAME_W),
      .BURST_W(BURST_W),
      .DEPTH  (FIFO_DEPTH)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (ctl_reset),
      .enable     (ctl_enable),
      .base       (cfg_base),
      .frame_words(cfg_frame_words),
      .burst_m1   (cfg_burst_m1),
      .fifo_level (fill),
      .req_valid  (mem_req_valid),
      .req_ready  (mem_req_ready),
      .req_addr   (mem_req_addr),
      .req_len_m1 (mem_req_len_m1),
      .rsp_valid  (mem_rsp_valid),
      .push       (push),
      .busy       (busy),
      .frame_done (frame_done)
   );

   fbf_fifo #(
      .DEPTH(FIFO_DEPTH),
      .DW   (DATA_W)
   ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (ctl_reset),
      .push     (push),
      .wdata    (mem_rsp_data),
      .pop_req  (pix_rd),
      .rdata    (pix_data),
      .empty    (pix_empty),
      .level    (fill),
      .underflow(pix_underflow)
   );
endmodule

// File: tb/sim_fbf_fetch_engine.sv
module sim_fbf_fetch_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [23:0] cfg_frame_words = '0;
   logic [4:0]  cfg_burst_m1 = '0;
   logic        ctl_enable = 1'b0;
   logic        ctl_reset = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic [4:0]  mem_req_len_m1;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        pix_rd = 1'b0;
   logic [31:0] pix_data;
   logic        pix_empty, pix_underflow, busy, frame_done;

   int n_chk = 0, n_bad = 0;
   int req_cnt = 0;
   int exp_off = 0;
   int rd_budget = 0;
   bit force_rd = 1'b0;
   bit after_burst = 1'b0;
   bit done_exp = 1'b0;
   logic [31:0] exp_q[$];

   always #2.5 clk = ~clk;

   fbf_fetch_engine u0 (.*);

   function automatic logic [31:0] memword(logic [31:0] a);
      return {a[15:0], ~a[15:0]};
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // memory model: checks each request against the frame position (R2, R3)
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (after_burst) begin
            chk(frame_done == done_exp, "R4 frame_done after burst", frame_done, done_exp);
            chk(busy == 1'b0, "R7 busy after last beat", busy, 0);
            after_burst = 1'b0;
         end
         if (mem_req_valid) begin
            automatic int exp_len = cfg_burst_m1 + 1;
            automatic logic [31:0] a = mem_req_addr;
            automatic int len = mem_req_len_m1 + 1;
            if (cfg_frame_words - exp_off < exp_len) exp_len = cfg_frame_words - exp_off;
            chk(a == cfg_base + 4 * exp_off, "R2 request address", a, cfg_base + 4 * exp_off);
            chk(len == exp_len, "R3 request length", len, exp_len);
            req_cnt++;
            for (int b = 0; b < len; b++) begin
               @(negedge clk);
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = memword(a + 4 * b);
               chk(busy == 1'b1, "R7 busy during burst", busy, 1);
            end
            done_exp = (exp_off + exp_len >= cfg_frame_words);
            exp_off  = done_exp ? 0 : exp_off + exp_len;
            after_burst = 1'b1;
         end
      end
   end

   // scoreboard monitor (R8)
   initial begin
      forever begin
         @(negedge clk);
         pix_rd = 1'b0;
         if (force_rd) pix_rd = 1'b1;
         else if (rd_budget > 0 && !pix_empty && exp_q.size() > 0) begin
            automatic logic [31:0] e = exp_q.pop_front();
            chk(pix_data == e, "R8 pixel word order", pix_data, e);
            rd_budget--;
            pix_rd = 1'b1;
         end
      end
   end

   task automatic push_exp(int n);
      for (int k = 0; k < n; k++)
         exp_q.push_back(memword(cfg_base + 4 * (k % cfg_frame_words)));
   endtask

   task automatic stop_and_reset();
      ctl_enable = 1'b0;
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
      @(negedge clk);
      ctl_reset = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(busy == 1'b0, "R1 idle during fetch reset", busy, 0);
      chk(pix_empty == 1'b1, "R10 store empty after fetch reset", pix_empty, 1);
      ctl_reset = 1'b0;
      exp_off = 0;
      exp_q.delete();
      rd_budget = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R7 busy at reset", busy, 0);
      chk(pix_empty == 1'b1, "R8 empty at reset", pix_empty, 1);
      chk(mem_req_valid == 1'b0, "R1 no request at reset", mem_req_valid, 0);
      chk(frame_done == 1'b0, "R4 no frame_done at reset", frame_done, 0);

      // two frames of 20 words, burst 8: lengths 8,8,4 then wrap (R2 R3 R4 R8)
      cfg_base = 32'h0000_1000; cfg_frame_words = 20; cfg_burst_m1 = 7;
      push_exp(40);
      rd_budget = 40;
      ctl_enable = 1'b1;
      for (int i = 0; i < 3000 && rd_budget > 0; i++) @(negedge clk);
      chk(rd_budget == 0, "R8 all words of two frames read", rd_budget, 0);
      stop_and_reset();

      // threshold: depth 512, burst 8 -> threshold 493, fill stops at 496 (R5 R10 R1)
      cfg_base = 32'h8000_0000; cfg_frame_words = 2000; cfg_burst_m1 = 7;
      push_exp(600);
      c0 = req_cnt;
      ctl_enable = 1'b1;
      repeat (1500) @(negedge clk);
      chk(req_cnt - c0 == 62, "R5 bursts until threshold", req_cnt - c0, 62);
      rd_budget = 3;
      repeat (80) @(negedge clk);
      chk(req_cnt - c0 == 62, "R5 no refill at level 493", req_cnt - c0, 62);
      rd_budget = 1;
      repeat (80) @(negedge clk);
      chk(req_cnt - c0 == 63, "R5 refill at level 492", req_cnt - c0, 63);
      ctl_enable = 1'b0;
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
      chk(pix_empty == 1'b0, "R10 store filled before reset", pix_empty, 0);
      stop_and_reset();

      // enable cleared while a burst is outstanding (R6)
      cfg_base = 32'h0000_4000; cfg_frame_words = 64; cfg_burst_m1 = 15;
      push_exp(16);
      c0 = req_cnt;
      ctl_enable = 1'b1;
      for (int i = 0; i < 50 && req_cnt == c0; i++) @(negedge clk);
      ctl_enable = 1'b0;
      repeat (60) @(negedge clk);
      chk(req_cnt - c0 == 1, "R6 single burst after disable", req_cnt - c0, 1);
      chk(busy == 1'b0, "R6 busy low after burst", busy, 0);
      rd_budget = 16;
      repeat (40) @(negedge clk);
      chk(rd_budget == 0, "R6 in-flight words delivered", rd_budget, 0);
      chk(pix_empty == 1'b1, "R6 nothing beyond the burst", pix_empty, 1);

      // underflow pulse (R9)
      @(posedge clk); force_rd = 1'b1;
      @(posedge clk); force_rd = 1'b0;
      @(negedge clk);
      chk(pix_underflow == 1'b1, "R9 underflow raised", pix_underflow, 1);
      @(negedge clk);
      chk(pix_underflow == 1'b0, "R9 underflow one cycle", pix_underflow, 0);
      chk(pix_empty == 1'b1, "R9 still empty", pix_empty, 1);
      stop_and_reset();

      summary();
      $finish;
   end
endmodule